// File: doc/BRIEF.md
# Capability Manipulation and Access Checker

This block works on tagged, bounded pointers. Each pointer carries a validity tag, a permission field, a base, a length and a current address. On a strobe the unit takes one source capability and one operation. It can narrow the permission field by masking it with an integer, move the address to a new value, or check whether a load, store or instruction fetch of a given size through the pointer may go ahead. The result is registered and presented one cycle later, with a fault flag and a two-bit cause code.

The unit is built so that rights can only shrink. No operation sets a permission bit that was clear in the source, or sets a tag that was clear in the source. The address may be moved anywhere, inside or outside the bounds, without any penalty. Only an access check compares the address with the bounds. That check also requires a valid tag and the permission bit that matches the access kind. A plain integer stored with the tag clear can be manipulated freely, but any access check through it faults.

Top module: `cap_guard_top`

## Requirements
- R1: Operation code 00 (mask permissions) returns the source with permissions set to the source permissions ANDed with the low permission-width bits of the operand. Tag, base, length and address are unchanged, and it never raises a fault.
- R2: Operation code 01 (set address) returns the source with the address replaced by the operand. Tag, permissions, base and length are unchanged, and it never raises a fault.
- R3: A mask or set-address operation on an untagged source returns a result with the tag clear and no fault.
- R4: A set-address operation that moves a tagged capability's address outside its bounds keeps the tag set and raises no fault.
- R5: Operation code 10 (check access) on an untagged source always faults with cause 01, whatever the permissions and bounds.
- R6: In a check, access kind 00 (load) needs permission bit 0, kind 01 (store) needs bit 1 and kind 10 (fetch) needs bit 2. Kind 11 is never permitted. If the needed bit is missing, the check faults with cause 10.
- R7: A check is in bounds only when address ≥ base and address + size ≤ base + length, with both sums taken at 65 bits so that a wrap past the top of the address space is caught. Otherwise the check faults with cause 11.
- R8: When several check conditions fail, the cause reported is the first of: tag (01), then permission (10), then bounds (11).
- R9: A check that passes reports fault 0 and cause 00, and returns the source capability unchanged.
- R10: `out_valid` is high exactly in the cycle after `in_valid` was high. When no strobe comes, every result output holds its value.
- R11: While reset is asserted, `out_valid`, `out_tag`, `out_fault` and `out_cause` are all 0.
- R12: Operation code 11 returns the source with the tag cleared and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code |
| in_tag | input | 1 | Source validity tag |
| in_perms | input | PERM_W | Source permissions |
| in_len | input | ADDR_W | Source length |
| in_base | input | ADDR_W | Source base |
| in_addr | input | ADDR_W | Source address |
| in_operand | input | ADDR_W | Integer operand (mask or new address) |
| in_size | input | SIZE_W | Access size in bytes |
| in_kind | input | 2 | Access kind |
| out_valid | output | 1 | Result valid |
| out_tag | output | 1 | Result tag |
| out_perms | output | PERM_W | Result permissions |
| out_len | output | ADDR_W | Result length |
| out_base | output | ADDR_W | Result base |
| out_addr | output | ADDR_W | Result address |
| out_fault | output | 1 | Access fault |
| out_cause | output | 2 | Fault cause |

## Verification
The bench builds the block with its default parameters: 64-bit address, base and length, 31 permission bits and an 8-bit size. With a 64-bit address the bench can place a region whose end lands exactly on 2^64, and drive accesses whose end runs one byte past it. This reaches the carry-out corner of the 65-bit bounds sums. The 8-bit size lets a single access start inside the region and cross its end by a byte or by hundreds of bytes.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int unsigned CAP_PERM_W = 31;
  localparam int unsigned CAP_ADDR_W = 64;
  localparam int unsigned CAP_SIZE_W = 8;

  typedef enum logic [1:0] {
    OP_AND_PERM = 2'b00,
    OP_SET_ADDR = 2'b01,
    OP_CHECK    = 2'b10,
    OP_RSVD     = 2'b11
  } cap_op_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_BAD   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_TAG    = 2'b01,
    CAUSE_PERM   = 2'b10,
    CAUSE_BOUNDS = 2'b11
  } cause_e;

endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cap_perm_unit.sv
module cap_perm_unit
  import cap_pkg::*;
#(
  parameter int unsigned PERM_W = CAP_PERM_W,
  parameter int unsigned LD_BIT = 0,
  parameter int unsigned ST_BIT = 1,
  parameter int unsigned FX_BIT = 2
) (
  input  logic [PERM_W-1:0] src_perms,
  input  logic [PERM_W-1:0] mask,
  input  acc_kind_e         kind,
  output logic [PERM_W-1:0] masked_perms,
  output logic              granted
);
  // Masking can only clear bits: the result is a subset of the source.
  assign masked_perms = src_perms & mask;

  always_comb begin
    unique case (kind)
      ACC_LOAD:  granted = src_perms[LD_BIT];
      ACC_STORE: granted = src_perms[ST_BIT];
      ACC_FETCH: granted = src_perms[FX_BIT];
      default:   granted = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SIZE_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              in_range
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] access_end;
  logic [EXT_W-1:0] region_end;
  logic             low_ok;
  logic             high_ok;

  // One extra bit on both sums keeps the carry out of the top of the space.
  assign access_end = {1'b0, addr} + EXT_W'(size);
  assign region_end = {1'b0, base} + {1'b0, len};
  assign low_ok     = (addr >= base);
  assign high_ok    = (access_end <= region_end);
  assign in_range   = low_ok & high_ok;
endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
  import cap_pkg::*;
(
  input  logic   enable,
  input  logic   tag_ok,
  input  logic   perm_ok,
  input  logic   range_ok,
  output logic   fault,
  output cause_e cause
);
  always_comb begin
    cause = CAUSE_NONE;
    if (enable) begin
      if (!tag_ok)        cause = CAUSE_TAG;
      else if (!perm_ok)  cause = CAUSE_PERM;
      else if (!range_ok) cause = CAUSE_BOUNDS;
    end
  end

  assign fault = (cause != CAUSE_NONE);
endmodule

// File: rtl/cap_guard_top.sv
module cap_guard_top
  import cap_pkg::*;
#(
  parameter int unsigned PERM_W = CAP_PERM_W,
  parameter int unsigned ADDR_W = CAP_ADDR_W,
  parameter int unsigned SIZE_W = CAP_SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic              in_tag,
  input  logic [PERM_W-1:0] in_perms,
  input  logic [ADDR_W-1:0] in_len,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] in_operand,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [1:0]        in_kind,
  output logic              out_valid,
  output logic              out_tag,
  output logic [PERM_W-1:0] out_perms,
  output logic [ADDR_W-1:0] out_len,
  output logic [ADDR_W-1:0] out_base,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault,
  output logic [1:0]        out_cause
);
  logic rst_sync_n;

  cap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cap_op_e   op;
  acc_kind_e kind;
  assign op   = cap_op_e'(in_op);
  assign kind = acc_kind_e'(in_kind);

  logic [PERM_W-1:0] masked_perms;
  logic              perm_granted;
  logic              range_ok;
  logic              chk_fault;
  cause_e            chk_cause;

  cap_perm_unit #(.PERM_W(PERM_W)) u_perm (
    .src_perms    (in_perms),
    .mask         (in_operand[PERM_W-1:0]),
    .kind         (kind),
    .masked_perms (masked_perms),
    .granted      (perm_granted)
  );

  cap_bounds_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
    .base     (in_base),
    .len      (in_len),
    .addr     (in_addr),
    .size     (in_size),
    .in_range (range_ok)
  );

  cap_fault_prio u_prio (
    .enable   (op == OP_CHECK),
    .tag_ok   (in_tag),
    .perm_ok  (perm_granted),
    .range_ok (range_ok),
    .fault    (chk_fault),
    .cause    (chk_cause)
  );

  // Next-state computation
  logic              nx_tag;
  logic [PERM_W-1:0] nx_perms;
  logic [ADDR_W-1:0] nx_addr;
  logic              nx_fault;
  cause_e            nx_cause;

  always_comb begin
    nx_tag   = in_tag;
    nx_perms = in_perms;
    nx_addr  = in_addr;
    nx_fault = 1'b0;
    nx_cause = CAUSE_NONE;
    unique case (op)
      OP_AND_PERM: nx_perms = masked_perms;
      OP_SET_ADDR: nx_addr  = in_operand;
      OP_CHECK: begin
        nx_fault = chk_fault;
        nx_cause = chk_cause;
      end
      default:     nx_tag   = 1'b0;
    endcase
  end

  // Result registers, loaded only on a strobe
  logic              valid_q;
  logic              tag_q;
  logic [PERM_W-1:0] perms_q;
  logic [ADDR_W-1:0] len_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fault_q;
  cause_e            cause_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tag_q   <= 1'b0;
      perms_q <= '0;
      len_q   <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (in_valid) begin
      tag_q   <= nx_tag;
      perms_q <= nx_perms;
      len_q   <= in_len;
      base_q  <= in_base;
      addr_q  <= nx_addr;
      fault_q <= nx_fault;
      cause_q <= nx_cause;
    end
  end

  assign out_valid = valid_q;
  assign out_tag   = tag_q;
  assign out_perms = perms_q;
  assign out_len   = len_q;
  assign out_base  = base_q;
  assign out_addr  = addr_q;
  assign out_fault = fault_q;
  assign out_cause = cause_q;

  // Assertions
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_perms) && $stable(out_tag)
                   && $stable(out_fault) && $stable(out_cause)));
  a_r1_perm_shrink: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == 2'b00) |=> ((out_perms & ~$past(in_perms)) == '0));
  a_r1_bounds_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (out_base == $past(in_base) && out_len == $past(in_len)));
  a_r3_no_tag_gain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_tag) |=> !out_tag);
  a_r2_manip_no_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op != 2'b10) |=> (!out_fault && out_cause == 2'b00));
  a_r5_untagged_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == 2'b10 && !in_tag) |=> (out_fault && out_cause == 2'b01));
  a_r12_rsvd_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == 2'b11) |=> (!out_tag && !out_fault));
endmodule

// File: tb/cap_guard_top_tb_top.sv
module cap_guard_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        tag;
    logic [30:0] perms;
    logic [63:0] len;
    logic [63:0] base;
    logic [63:0] addr;
    logic        fault;
    logic [1:0]  cause;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic        in_tag;
  logic [30:0] in_perms;
  logic [63:0] in_len, in_base, in_addr, in_operand;
  logic [7:0]  in_size;
  logic [1:0]  in_kind;
  logic        out_valid, out_tag, out_fault;
  logic [30:0] out_perms;
  logic [63:0] out_len, out_base, out_addr;
  logic [1:0]  out_cause;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_guard_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_tag(in_tag), .in_perms(in_perms), .in_len(in_len), .in_base(in_base),
    .in_addr(in_addr), .in_operand(in_operand), .in_size(in_size),
    .in_kind(in_kind), .out_valid(out_valid), .out_tag(out_tag),
    .out_perms(out_perms), .out_len(out_len), .out_base(out_base),
    .out_addr(out_addr), .out_fault(out_fault), .out_cause(out_cause)
  );

  // Reference model written from the requirements
  function automatic exp_t model(input logic [1:0] op, input logic tag,
      input logic [30:0] perms, input logic [63:0] len, input logic [63:0] base,
      input logic [63:0] addr, input logic [63:0] operand, input logic [7:0] size,
      input logic [1:0] kind, input logic [7:0] req);
    exp_t e;
    logic perm_ok;
    logic rng_ok;
    e = '{tag: tag, perms: perms, len: len, base: base, addr: addr,
          fault: 1'b0, cause: 2'b00, req: req};
    case (kind)
      2'b00:   perm_ok = perms[0];
      2'b01:   perm_ok = perms[1];
      2'b10:   perm_ok = perms[2];
      default: perm_ok = 1'b0;
    endcase
    rng_ok = (addr >= base) &&
             (({1'b0, addr} + {57'd0, size}) <= ({1'b0, base} + {1'b0, len}));
    case (op)
      2'b00: e.perms = perms & operand[30:0];
      2'b01: e.addr  = operand;
      2'b10: begin
        if (!tag)          e.cause = 2'b01;
        else if (!perm_ok) e.cause = 2'b10;
        else if (!rng_ok)  e.cause = 2'b11;
        e.fault = (e.cause != 2'b00);
      end
      default: e.tag = 1'b0;
    endcase
    return e;
  endfunction

  task automatic apply(input logic [1:0] op, input logic tag, input logic [30:0] perms,
      input logic [63:0] len, input logic [63:0] base, input logic [63:0] addr,
      input logic [63:0] operand, input logic [7:0] size, input logic [1:0] kind,
      input logic [7:0] req);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_tag = tag; in_perms = perms; in_len = len;
    in_base = base; in_addr = addr; in_operand = operand; in_size = size; in_kind = kind;
    sb_q.push_back(model(op, tag, perms, len, base, addr, operand, size, kind, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_operand = 64'hDEAD_BEEF_0000_0000 + 64'(i);
    end
  endtask

  // Monitor: pops expected items as results appear; checks hold between results
  logic        have_prev = 1'b0;
  logic        p_tag, p_fault;
  logic [30:0] p_perms;
  logic [63:0] p_addr;
  logic [1:0]  p_cause;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        n_vec++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL R10: out_valid with no pending item (actual 1, expected 0)");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if ({out_tag, out_perms, out_len, out_base, out_addr, out_fault, out_cause} !==
              {e.tag, e.perms, e.len, e.base, e.addr, e.fault, e.cause}) begin
            n_bad++;
            $display("FAIL R%0d: actual tag=%b perms=%h len=%h base=%h addr=%h fault=%b cause=%b expected tag=%b perms=%h len=%h base=%h addr=%h fault=%b cause=%b",
              e.req, out_tag, out_perms, out_len, out_base, out_addr, out_fault, out_cause,
              e.tag, e.perms, e.len, e.base, e.addr, e.fault, e.cause);
          end
        end
        have_prev = 1'b1;
        p_tag = out_tag; p_perms = out_perms; p_addr = out_addr;
        p_fault = out_fault; p_cause = out_cause;
      end else if (have_prev) begin
        n_vec++;  // R10 hold check while idle
        if ({out_tag, out_perms, out_addr, out_fault, out_cause} !==
            {p_tag, p_perms, p_addr, p_fault, p_cause}) begin
          n_bad++;
          $display("FAIL R10: outputs moved while idle, actual addr=%h perms=%h expected addr=%h perms=%h",
                   out_addr, out_perms, p_addr, p_perms);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  localparam logic [30:0] P_ALL = 31'h7FFF_FFFF;
  localparam logic [63:0] TOPB  = 64'hFFFF_FFFF_FFFF_FF00;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_tag = 1'b0; in_perms = '0;
    in_len = '0; in_base = '0; in_addr = '0; in_operand = '0; in_size = '0; in_kind = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    n_vec++;
    if ({out_valid, out_tag, out_fault, out_cause} !== 5'b0) begin
      n_bad++;
      $display("FAIL R11: actual valid=%b tag=%b fault=%b cause=%b expected all 0",
               out_valid, out_tag, out_fault, out_cause);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: masking permissions
    apply(2'b00, 1, P_ALL, 64'h100, 64'h1000, 64'h1040, 64'h0000_0000_0000_0F05, 0, 0, 1);
    apply(2'b00, 1, 31'h0000_0007, 64'h100, 64'h1000, 64'h1040, 64'h0, 0, 0, 1);
    apply(2'b00, 1, 31'h0000_0005, 64'h100, 64'h1000, 64'h1040, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1);
    idle(2);
    // R2: set address in bounds
    apply(2'b01, 1, 31'h7, 64'h100, 64'h1000, 64'h1040, 64'h10F0, 0, 0, 2);
    // R4: set address far outside bounds keeps tag
    apply(2'b01, 1, 31'h7, 64'h100, 64'h1000, 64'h1040, 64'h9999_0000, 0, 0, 4);
    // R7: access through that out-of-bounds address faults on bounds
    apply(2'b10, 1, 31'h7, 64'h100, 64'h1000, 64'h9999_0000, 0, 4, 0, 7);
    // R3: manipulations on untagged values
    apply(2'b00, 0, 31'h7, 64'h0, 64'h0, 64'h1234, 64'h3, 0, 0, 3);
    apply(2'b01, 0, 31'h0, 64'h0, 64'h0, 64'h1234, 64'h5678, 0, 0, 3);
    idle(3);
    // R5 and R8: untagged check, also bad permission and out of range
    apply(2'b10, 0, 31'h0, 64'h10, 64'h1000, 64'h0, 0, 8, 0, 5);
    apply(2'b10, 0, 31'h7, 64'h100, 64'h1000, 64'h1000, 0, 4, 0, 5);
    // R6: permission by access kind
    apply(2'b10, 1, 31'h1, 64'h100, 64'h1000, 64'h1000, 0, 8, 0, 6); // load ok
    apply(2'b10, 1, 31'h1, 64'h100, 64'h1000, 64'h1000, 0, 8, 1, 6); // store denied
    apply(2'b10, 1, 31'h4, 64'h100, 64'h1000, 64'h1000, 0, 4, 2, 6); // fetch ok
    apply(2'b10, 1, 31'h2, 64'h100, 64'h1000, 64'h1000, 0, 4, 2, 6); // fetch denied
    apply(2'b10, 1, P_ALL, 64'h100, 64'h1000, 64'h1000, 0, 4, 3, 6); // kind 11
    // R8: permission outranks bounds
    apply(2'b10, 1, 31'h1, 64'h100, 64'h1000, 64'h2000, 0, 4, 1, 8);
    idle(1);
    // R7: region ending exactly at 2^64
    apply(2'b10, 1, 31'h7, 64'h100, TOPB, 64'hFFFF_FFFF_FFFF_FFF8, 0, 8, 0, 7);
    apply(2'b10, 1, 31'h7, 64'h100, TOPB, 64'hFFFF_FFFF_FFFF_FFF8, 0, 9, 0, 7);
    apply(2'b10, 1, 31'h7, 64'h100, TOPB, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2, 0, 7);
    apply(2'b10, 1, 31'h7, 64'h100, TOPB, 64'hFFFF_FFFF_FFFF_FFFF, 0, 255, 0, 7);
    // R7: below base, and an access crossing the end by many bytes
    apply(2'b10, 1, 31'h7, 64'h100, 64'h1000, 64'h0FFF, 0, 1, 0, 7);
    apply(2'b10, 1, 31'h7, 64'h100, 64'h1000, 64'h10F0, 0, 200, 1, 7);
    // R9: exact fit and zero size at the end
    apply(2'b10, 1, 31'h7, 64'h100, 64'h1000, 64'h10F8, 0, 8, 1, 9);
    apply(2'b10, 1, 31'h7, 64'h100, 64'h1000, 64'h1100, 0, 0, 0, 9);
    // R12: reserved operation clears tag
    apply(2'b11, 1, P_ALL, 64'h100, 64'h1000, 64'h1010, 64'h55, 4, 0, 12);
    idle(4);
    // R10: back-to-back strobes after idle
    apply(2'b01, 1, 31'h3, 64'h40, 64'h2000, 64'h2000, 64'h2020, 0, 0, 10);
    apply(2'b00, 1, 31'h3, 64'h40, 64'h2000, 64'h2020, 64'h1, 0, 0, 10);
    idle(4);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d results never appeared (actual %0d, expected 0)",
               sb_q.size(), sb_q.size());
    end
    finish_run();
  end
endmodule